// File: doc/BRIEF.md
# Synchronous Transfer Strobe Divider

This block turns one core clock into two strobes for a synchronous parallel bus. The send strobe and the receive strobe are single-cycle enable pulses in the core clock domain. The core clock first passes a prescaler, whose divisor is chosen by a 3-bit field and may be the fractional value 1.5. The prescaled rate then feeds two dividers. The send divider divides by a programmable transfer period of 4 to 11 prescaled ticks. The receive divider always divides by 4.

Logic that runs at the core clock uses the strobes as clock enables. Each divider reads its selection field only at the end of a period. A new setting therefore starts cleanly, and no period is ever cut short. Example: with a 40 MHz core clock, a prescale divisor of 1 and a transfer-period code of 0, both strobes arrive at 10 MHz.

The prescaled rate is meant to stay at or below 50 MHz. The highest core clock that may be used therefore depends on the prescale setting. This limit is a usage rule and is not enforced by the block.

Top module: `xfer_clkdiv`

## Requirements
- R1: Prescale code 3'b001 divides by 1: one prescaled tick every core cycle, so the receive strobe fires every 4 cycles.
- R2: Prescale code 3'b010 divides by 1.5: prescaled ticks come with gaps of 1 and 2 cycles that alternate, 2 ticks every 3 cycles, so the receive strobe fires every 6 cycles.
- R3: Prescale code 3'b011 divides by 2, so the receive strobe fires every 8 cycles.
- R4: Prescale codes 3'b100 and 3'b000 divide by 3, so the receive strobe fires every 12 cycles.
- R5: The unassigned prescale codes 3'b101, 3'b110 and 3'b111 also divide by 3.
- R6: The send strobe fires once every (4 + period code) prescaled ticks. The period code is the 3-bit value on per_sel, so a send period lasts prescale divisor × (4 + code) core cycles.
- R7: The receive strobe fires once every 4 prescaled ticks, whatever the period code is.
- R8: Each strobe pulse lasts exactly one core cycle.
- R9: A synchronous reset clears all counters. No strobe is high while reset is held, nor in the first cycle after it is released. After release, prescaled tick k arrives at edge ceil(k × divisor). A strobe rises one edge after the prescaled tick that completes its period.
- R10: A change on pre_sel or per_sel takes effect only when the counter it controls wraps. The period that is running finishes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_sel | input | 3 | Prescale divisor select |
| per_sel | input | 3 | Send transfer-period select, divisor is 4 + code |
| send_tick | output | 1 | Single-cycle send enable pulse |
| recv_tick | output | 1 | Single-cycle receive enable pulse |

## Verification
The bench uses the default parameters: a 3-bit period field with base 4, and a fixed receive period of 4. All 64 combinations of prescale code and period code can then be swept one by one. Each combination runs from reset for 80 edges, which covers at least two full send periods even at the slowest setting of 33 cycles. The expected strobes come from a floor-division count of prescaled ticks, which exercises the fractional 1.5 pattern and the alias codes at every phase. Two separate runs change a selection field in the middle of a period to check that the change is held back until the wrap.

// File: rtl/xfer_clkdiv_pkg.sv
package xfer_clkdiv_pkg;

  localparam int PRE_W = 3;

  // Prescale as a ratio: num ticks out for every den core cycles
  typedef struct packed {
    logic [1:0] num;
    logic [1:0] den;
  } pre_ratio_t;

  function automatic pre_ratio_t pre_ratio(input logic [PRE_W-1:0] sel);
    pre_ratio_t r;
    case (sel)
      3'b001:  r = '{num: 2'd1, den: 2'd1};
      3'b010:  r = '{num: 2'd2, den: 2'd3};
      3'b011:  r = '{num: 2'd1, den: 2'd2};
      default: r = '{num: 2'd1, den: 2'd3};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xfer_prescaler.sv
module xfer_prescaler
  import xfer_clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);

  pre_ratio_t cfg_q;
  logic [1:0] acc_q;
  logic [2:0] sum;
  logic [2:0] acc_n;
  logic       hit;
  logic       wrap;

  // Fractional accumulator: fires whenever num reaches den
  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, cfg_q.num};
    hit   = (sum >= {1'b0, cfg_q.den});
    acc_n = hit ? (sum - {1'b0, cfg_q.den}) : sum;
    wrap  = (acc_n == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 2'd0;
      cfg_q <= pre_ratio(sel);
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_n[1:0];
      tick  <= hit;
      if (wrap) cfg_q <= pre_ratio(sel);
    end
  end

endmodule

// File: rtl/xfer_period_div.sv
module xfer_period_div #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] period_in,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic             last;
  logic             wrap;

  assign last = (cnt_q == per_q - CNT_W'(1));
  assign wrap = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= period_in;
      tick  <= 1'b0;
    end else begin
      tick <= wrap;
      if (step) begin
        if (last) begin
          cnt_q <= '0;
          per_q <= period_in;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/xfer_clkdiv.sv
module xfer_clkdiv #(
  parameter int PER_W     = 3,
  parameter int PER_BASE  = 4,
  parameter int RX_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       pre_sel,
  input  logic [PER_W-1:0] per_sel,
  output logic             send_tick,
  output logic             recv_tick
);

  localparam int MAX_PER = PER_BASE + (1 << PER_W) - 1;
  localparam int TOP_PER = (MAX_PER > RX_PERIOD) ? MAX_PER : RX_PERIOD;
  localparam int CNT_W   = $clog2(TOP_PER + 1);

  logic             pre_tick;
  logic [CNT_W-1:0] tx_period;
  logic [CNT_W-1:0] rx_period;

  assign tx_period = CNT_W'(PER_BASE) + CNT_W'(per_sel);
  assign rx_period = CNT_W'(RX_PERIOD);

  xfer_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (pre_sel),
    .tick (pre_tick)
  );

  xfer_period_div #(.CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .step      (pre_tick),
    .period_in (tx_period),
    .tick      (send_tick)
  );

  xfer_period_div #(.CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .step      (pre_tick),
    .period_in (rx_period),
    .tick      (recv_tick)
  );

endmodule

// File: rtl/xfer_clkdiv_chk.sv
module xfer_clkdiv_chk #(
  parameter int RX_PERIOD = 4
) (
  input logic clk,
  input logic rst,
  input logic pre_tick,
  input logic send_tick,
  input logic recv_tick
);

  logic [7:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)            pc_q <= 8'd0;
    else if (recv_tick) pc_q <= {7'd0, pre_tick};
    else                pc_q <= pc_q + {7'd0, pre_tick};
  end

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst) send_tick |=> !send_tick); // R8
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst) recv_tick |=> !recv_tick); // R8
  AST_TX_AFTER_PRE: assert property (@(posedge clk) disable iff (rst) send_tick |-> $past(pre_tick)); // R6
  AST_RX_FOUR: assert property (@(posedge clk) disable iff (rst) recv_tick |-> (pc_q == 8'(RX_PERIOD))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!send_tick && !recv_tick)); // R9

endmodule

bind xfer_clkdiv xfer_clkdiv_chk #(.RX_PERIOD(RX_PERIOD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pre_tick  (pre_tick),
  .send_tick (send_tick),
  .recv_tick (recv_tick)
);

// File: tb/xfer_clkdiv_tb.sv
`timescale 1ns/1ps
module xfer_clkdiv_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pre_sel = 3'd1;
  logic [2:0] per_sel = 3'd0;
  logic       send_tick;
  logic       recv_tick;
  int         checks = 0;
  int         fails  = 0;

  always #2 clk = ~clk;

  xfer_clkdiv u_dut (
    .clk       (clk),
    .rst       (rst),
    .pre_sel   (pre_sel),
    .per_sel   (per_sel),
    .send_tick (send_tick),
    .recv_tick (recv_tick)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Twice the prescale divisor for a code
  function automatic int div2(input int code);
    case (code)
      1: return 2;
      2: return 3;
      3: return 4;
      default: return 6;
    endcase
  endfunction

  // Prescaled ticks completed after n edges
  function automatic int pcount(input int n, input int d2);
    return (n <= 0) ? 0 : (2 * n) / d2;
  endfunction

  function automatic logic strobe_at(input int m, input int d2, input int p);
    if (m < 2) return 1'b0;
    return (pcount(m - 1, d2) / p) != (pcount(m - 2, d2) / p);
  endfunction

  function automatic string pre_tag(input int code);
    case (code)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      0, 4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_reset;
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 reset send", send_tick, 1'b0);
    check("R9 reset recv", recv_tick, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Full sweep of prescale and period codes
    for (int pc = 0; pc < 8; pc++) begin
      for (int tc = 0; tc < 8; tc++) begin
        int  d2;
        int  p;
        logic prev_s;
        pre_sel = 3'(pc);
        per_sel = 3'(tc);
        d2 = div2(pc);
        p  = 4 + tc;
        prev_s = 1'b0;
        do_reset();
        for (int m = 1; m <= 80; m++) begin
          @(posedge clk);
          @(negedge clk);
          if (m == 1) check("R9 first cycle", send_tick | recv_tick, 1'b0);
          check("R6 send", send_tick, strobe_at(m, d2, p));
          check(tc != 0 ? "R7 recv" : pre_tag(pc), recv_tick, strobe_at(m, d2, 4));
          if (prev_s) check("R8 send width", send_tick, 1'b0);
          prev_s = send_tick;
        end
      end
    end

    // R10: period change mid-period waits for the wrap
    pre_sel = 3'd1;
    per_sel = 3'd0;
    do_reset();
    for (int m = 1; m <= 20; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == 2) per_sel = 3'd7;
      check("R10 period change", send_tick, (m == 5) || (m == 16));
    end

    // R10: prescale change waits for the prescaler wrap
    pre_sel = 3'd4;
    per_sel = 3'd0;
    do_reset();
    for (int m = 1; m <= 12; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == 1) pre_sel = 3'd1;
      check("R10 prescale change", recv_tick, (m == 7) || (m == 11));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule